// File: doc/BRIEF.md
# Block Address Translation Matcher

This unit translates a 32-bit effective address through a small set of large-block mapping entries. There are two sets of four entries: one serves instruction fetches, the other serves every other kind of access. Each entry is a pair of 32-bit words. The upper word says which virtual block the entry covers, how large that block is, and in which privilege states the entry is live. The lower word gives the physical block base and the access rights.

Software loads the entries one word at a time through a register-write port. Lookups are purely combinational. The result is a hit flag, a 4 KiB-aligned physical page address, read and write grants, and a combined access-allowed flag for the current read/write direction. When translation is switched off for the side being accessed, the address passes through untranslated with full rights. A miss leaves every output at zero, so that a later segment-based stage can take over.

Top module: `bat_matcher`

## Requirements
- R1: A lookup with `isCode`=1 uses only the instruction-side entries (write addresses with `wrAddr[3]`=0). Any other lookup uses only the data-side entries (`wrAddr[3]`=1).
- R2: An entry matches only when two comparisons hold. `effAddr[31:28]` must equal upper-word bits [31:28]. `effAddr[27:17]`, with the length-masked bits cleared, must equal upper-word bits [27:17] exactly.
- R3: The block-length mask is upper-word bits [12:2], aligned to address bits [27:17]. A set mask bit removes that address bit from the compare, so the block grows from 128 KiB up to 256 MiB.
- R4: Upper-word bit 1 makes an entry usable in supervisor state (`userMode`=0). Upper-word bit 0 makes it usable in user state (`userMode`=1). A matching entry whose bit for the current state is clear does not hit.
- R5: When several entries qualify, the one with the lowest index wins.
- R6: On a hit, `physPage` is built from three parts: [31:28] from lower-word [31:28]; [27:17] as (`effAddr[27:17]` AND mask) OR lower-word [27:17]; [16:12] from `effAddr[16:12]`.
- R7: On a hit, lower-word bit 1 set grants read and write. Otherwise lower-word bit 0 set grants read only. With neither bit set, no access is granted.
- R8: If `codeXlateEn`=0 for a code lookup, or `dataXlateEn`=0 for a data lookup, the outputs are `hit`=1, `physPage`={`effAddr[31:12]`,12'h0}, and read and write are both granted.
- R9: On a miss, `hit`, `canRead`, `canWrite`, `accessOk` and `physPage` are all zero.
- R10: `physPage[11:0]` is always zero. Every output follows the lookup inputs in the same cycle.
- R11: After reset every entry word is zero, so no translated lookup hits.
- R12: A write with `wrEn`=1 stores `wrData` at the next clock edge. The target is chosen by `wrAddr`: bit 3 picks the side (0 = instruction, 1 = data), bits [2:1] pick the entry index, and bit 0 picks the word (0 = upper, 1 = lower).
- R13: `accessOk` equals `hit` AND (`isWrite` ? `canWrite` : `canRead`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for entry writes |
| rstN | input | 1 | Active-low reset; clears all entries |
| wrEn | input | 1 | Entry word write strobe |
| wrAddr | input | 4 | Side, entry index and word select for a write |
| wrData | input | 32 | Word to store |
| effAddr | input | 32 | Effective address to translate |
| isCode | input | 1 | 1 for an instruction fetch, 0 for any other access |
| isWrite | input | 1 | 1 for a store, 0 for a load |
| userMode | input | 1 | 1 in user state, 0 in supervisor state |
| codeXlateEn | input | 1 | Instruction-side translation enable |
| dataXlateEn | input | 1 | Data-side translation enable |
| hit | output | 1 | Translation found, or bypass |
| physPage | output | 32 | Physical page address, low 12 bits zero |
| canRead | output | 1 | Read permitted |
| canWrite | output | 1 | Write permitted |
| accessOk | output | 1 | Access allowed for the current direction |

## Verification
The assertions take no shape of entry contents for granted; they assume only that the lookup inputs are stable and known around each clock edge while `rstN` is high. The bench meets this by changing every input just after the falling edge and leaving it untouched until the next one. Entry words are generated in two ways. Some are well-formed: the compare field is clear wherever the mask is set, and the mask is a contiguous run of low ones. Others are raw pseudo-random words. The well-formed words reach the hit paths, and the raw words exercise the cases where an entry can never match. Addresses are derived from a chosen entry's upper word, so that hits, privilege misses and cross-side misses all occur often.

// File: rtl/bat_pkg.sv
package bat_pkg;
  parameter int NUM_ENTRIES = 4;
  localparam int IDX_W    = $clog2(NUM_ENTRIES);
  localparam int WORD_W   = 32;
  localparam int WADDR_W  = IDX_W + 2;
  localparam int NUM_SIDES = 2;
  // compare field geometry
  localparam int BLK_LO   = 17;
  localparam int BLK_HI   = 27;
  localparam int BLK_W    = BLK_HI - BLK_LO + 1;
  localparam int LEN_LO   = 2;
  localparam int PAGE_LO  = 12;

  typedef struct packed {
    logic             wrUpper;
    logic             wrLower;
    logic             wrDataSide;
    logic [IDX_W-1:0] wrIdx;
    logic             lookData;
    logic             bypass;
  } batCtrl_t;
endpackage

// File: rtl/bat_ctrl.sv
module bat_ctrl
  import bat_pkg::*;
(
  input  logic               wrEn,
  input  logic [WADDR_W-1:0] wrAddr,
  input  logic               isCode,
  input  logic               codeXlateEn,
  input  logic               dataXlateEn,
  output batCtrl_t           ctrl
);
  always_comb begin
    ctrl.wrUpper    = wrEn & ~wrAddr[0];
    ctrl.wrLower    = wrEn &  wrAddr[0];
    ctrl.wrDataSide = wrAddr[WADDR_W-1];
    ctrl.wrIdx      = wrAddr[IDX_W:1];
    ctrl.lookData   = ~isCode;
    ctrl.bypass     = isCode ? ~codeXlateEn : ~dataXlateEn;
  end
endmodule

// File: rtl/bat_datapath.sv
module bat_datapath
  import bat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  batCtrl_t          ctrl,
  input  logic [WORD_W-1:0] wrData,
  input  logic [WORD_W-1:0] effAddr,
  input  logic              userMode,
  input  logic              isWrite,
  output logic              hit,
  output logic [WORD_W-1:0] physPage,
  output logic              canRead,
  output logic              canWrite,
  output logic              accessOk
);
  logic [WORD_W-1:0] upperW [NUM_SIDES][NUM_ENTRIES];
  logic [WORD_W-1:0] lowerW [NUM_SIDES][NUM_ENTRIES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SIDES; s++)
        for (int e = 0; e < NUM_ENTRIES; e++) begin
          upperW[s][e] <= '0;
          lowerW[s][e] <= '0;
        end
    end else begin
      if (ctrl.wrUpper) upperW[ctrl.wrDataSide][ctrl.wrIdx] <= wrData;
      if (ctrl.wrLower) lowerW[ctrl.wrDataSide][ctrl.wrIdx] <= wrData;
    end
  end

  logic [NUM_ENTRIES-1:0] entHit;
  logic [WORD_W-1:0]      entPhys [NUM_ENTRIES];
  logic [1:0]             entProt [NUM_ENTRIES];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    logic [WORD_W-1:0] upW, loW;
    logic [BLK_W-1:0]  lenMask;
    logic              privOk;
    assign upW     = upperW[ctrl.lookData][g];
    assign loW     = lowerW[ctrl.lookData][g];
    assign lenMask = upW[LEN_LO +: BLK_W];
    assign privOk  = userMode ? upW[0] : upW[1];
    assign entHit[g] = privOk
                     && (effAddr[WORD_W-1:BLK_HI+1] == upW[WORD_W-1:BLK_HI+1])
                     && ((effAddr[BLK_HI:BLK_LO] & ~lenMask) == upW[BLK_HI:BLK_LO]);
    assign entPhys[g] = {loW[WORD_W-1:BLK_HI+1],
                         (effAddr[BLK_HI:BLK_LO] & lenMask) | loW[BLK_HI:BLK_LO],
                         effAddr[BLK_LO-1:PAGE_LO],
                         {PAGE_LO{1'b0}}};
    assign entProt[g] = loW[1:0];
  end

  always_comb begin
    hit      = 1'b0;
    physPage = '0;
    canRead  = 1'b0;
    canWrite = 1'b0;
    if (ctrl.bypass) begin
      hit      = 1'b1;
      physPage = {effAddr[WORD_W-1:PAGE_LO], {PAGE_LO{1'b0}}};
      canRead  = 1'b1;
      canWrite = 1'b1;
    end else begin
      for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
        if (entHit[i]) begin
          hit      = 1'b1;
          physPage = entPhys[i];
          canWrite = entProt[i][1];
          canRead  = entProt[i][1] | entProt[i][0];
        end
      end
    end
    accessOk = hit & (isWrite ? canWrite : canRead);
  end
endmodule

// File: rtl/bat_matcher.sv
module bat_matcher
  import bat_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [WADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0]  wrData,
  input  logic [WORD_W-1:0]  effAddr,
  input  logic               isCode,
  input  logic               isWrite,
  input  logic               userMode,
  input  logic               codeXlateEn,
  input  logic               dataXlateEn,
  output logic               hit,
  output logic [WORD_W-1:0]  physPage,
  output logic               canRead,
  output logic               canWrite,
  output logic               accessOk
);
  batCtrl_t ctrl;

  bat_ctrl ctrl_i (
    .wrEn(wrEn), .wrAddr(wrAddr), .isCode(isCode),
    .codeXlateEn(codeXlateEn), .dataXlateEn(dataXlateEn), .ctrl(ctrl)
  );

  bat_datapath dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrData(wrData), .effAddr(effAddr),
    .userMode(userMode), .isWrite(isWrite), .hit(hit), .physPage(physPage),
    .canRead(canRead), .canWrite(canWrite), .accessOk(accessOk)
  );
endmodule

// File: rtl/bat_matcher_chk.sv
module bat_matcher_chk
  import bat_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] effAddr,
  input logic              isCode,
  input logic              isWrite,
  input logic              codeXlateEn,
  input logic              dataXlateEn,
  input logic              hit,
  input logic [WORD_W-1:0] physPage,
  input logic              canRead,
  input logic              canWrite,
  input logic              accessOk
);
  logic offMode;
  assign offMode = isCode ? !codeXlateEn : !dataXlateEn;

  // R8
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    offMode |-> (hit && canRead && canWrite && physPage[31:12] == effAddr[31:12]));
  // R10
  page_offset_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    physPage[PAGE_LO-1:0] == '0);
  // R7
  write_implies_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    canWrite |-> canRead);
  // R9
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (!canRead && !canWrite && !accessOk && physPage == '0));
  // R6
  low_page_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (physPage[BLK_LO-1:PAGE_LO] == effAddr[BLK_LO-1:PAGE_LO]));
  // R13
  access_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessOk |-> (hit && (isWrite ? canWrite : canRead)));
endmodule

bind bat_matcher bat_matcher_chk chk_i (.*);

// File: tb/bat_matcher_tb_top.sv
module bat_matcher_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] effAddr = '0;
  logic        isCode = 1'b0, isWrite = 1'b0, userMode = 1'b0;
  logic        codeXlateEn = 1'b1, dataXlateEn = 1'b1;
  logic        hit, canRead, canWrite, accessOk;
  logic [31:0] physPage;

  int testsRun = 0;
  int testsFailed = 0;
  logic [31:0] shUp [2][4];
  logic [31:0] shLo [2][4];
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  bat_matcher dut_i (.*);

  function automatic logic [31:0] nextRnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // expected outputs: {hit, canRead, canWrite, accessOk, physPage}
  function automatic logic [35:0] expect_out();
    logic        h = 0, r = 0, w = 0;
    logic [31:0] p = '0;
    int side = isCode ? 0 : 1;
    if ((isCode && !codeXlateEn) || (!isCode && !dataXlateEn)) begin
      h = 1; r = 1; w = 1; p = effAddr & 32'hFFFF_F000;
    end else begin
      for (int e = 3; e >= 0; e--) begin
        logic [31:0] m = (shUp[side][e] & 32'h0000_1FFC) << 15;
        logic v = userMode ? shUp[side][e][0] : shUp[side][e][1];
        if (v && (effAddr[31:28] == shUp[side][e][31:28]) &&
            ((effAddr & 32'h0FFE_0000 & ~m) == (shUp[side][e] & 32'h0FFE_0000))) begin
          h = 1;
          p = (shLo[side][e] & 32'hF000_0000) | (effAddr & m) |
              (shLo[side][e] & 32'h0FFE_0000) | (effAddr & 32'h0001_F000);
          w = shLo[side][e][1];
          r = shLo[side][e][1] | shLo[side][e][0];
        end
      end
    end
    return {h, r, w, h & (isWrite ? w : r), p};
  endfunction

  task automatic check(input string req);
    logic [35:0] exp = expect_out();
    logic [35:0] act = {hit, canRead, canWrite, accessOk, physPage};
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s ea=%h code=%0d usr=%0d wr=%0d act=%h exp=%h",
               req, effAddr, isCode, userMode, isWrite, act, exp);
    end
  endtask

  task automatic wr_word(input logic side, input int idx, input logic lo, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = {side, idx[1:0], lo}; wrData = d;
    @(negedge clk);
    wrEn = 0;
    if (lo) shLo[side][idx] = d; else shUp[side][idx] = d;
  endtask

  task automatic look(input logic [31:0] a, input logic c, input logic u, input logic w, input string req);
    @(negedge clk);
    effAddr = a; isCode = c; userMode = u; isWrite = w;
    #5 check(req);
  endtask

  function automatic logic [31:0] mk_upper(input logic [31:0] r, input int k);
    logic [10:0] m = 11'((32'd1 << k) - 1);
    return {r[31:28], r[27:17] & ~m, 4'h0, m, r[1:0]};
  endfunction

  initial begin
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 4; e++) begin shUp[s][e] = '0; shLo[s][e] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    // R11 R9: cleared entries never hit
    look(32'h0000_0000, 1, 0, 0, "R11");
    look(32'h0000_0000, 0, 1, 1, "R11");
    for (int i = 0; i < 20; i++) look(nextRnd(), i[0], i[1], i[2], "R9");
    // R8 R10 bypass
    codeXlateEn = 0;
    look(32'hDEAD_BEEF, 1, 1, 1, "R8");
    look(32'hDEAD_BEEF, 0, 1, 1, "R9");
    codeXlateEn = 1; dataXlateEn = 0;
    look(32'h1234_5FFF, 0, 0, 0, "R8");
    look(32'h1234_5FFF, 1, 0, 0, "R10");
    dataXlateEn = 1;
    // R12 R1 R6: code entry 0, 128 KiB block, supervisor only, rw
    wr_word(0, 0, 0, 32'h1000_0002);
    wr_word(0, 0, 1, 32'h8000_0002);
    look(32'h1001_5123, 1, 0, 1, "R6");
    look(32'h1001_5123, 0, 0, 0, "R1");
    look(32'h1001_5123, 1, 1, 0, "R4");
    look(32'h1002_0000, 1, 0, 0, "R2");
    // R1 data side entry, user only, read only
    wr_word(1, 1, 0, 32'h1000_0001);
    wr_word(1, 1, 1, 32'h4002_0001);
    look(32'h1001_F000, 0, 1, 0, "R1");
    look(32'h1001_F000, 0, 1, 1, "R13");
    look(32'h1001_F000, 0, 0, 0, "R4");
    // R3 mask: 1 MiB block on code entry 2 (mask 3 bits), no rights
    wr_word(0, 2, 0, {4'h2, 11'h000, 4'h0, 11'h007, 2'b11});
    wr_word(0, 2, 1, 32'hA000_0000);
    look(32'h200E_3000, 1, 1, 0, "R3");
    look(32'h2010_0000, 1, 1, 0, "R3");
    look(32'h200E_3000, 1, 0, 0, "R7");
    // R5 priority: code entry 1 overlaps entry 2, entry 1 wins
    wr_word(0, 1, 0, {4'h2, 11'h000, 4'h0, 11'h00F, 2'b11});
    wr_word(0, 1, 1, 32'hB000_0001);
    look(32'h200E_3000, 1, 1, 0, "R5");
    look(32'h200E_3000, 1, 1, 1, "R5");
    // sweeps: random entry sets, addresses aimed at entries
    for (int it = 0; it < 150; it++) begin
      for (int s = 0; s < 2; s++)
        for (int e = 0; e < 4; e++) begin
          logic [31:0] r = nextRnd();
          wr_word(s[0], e, 0, (r[5:4] == 0) ? nextRnd() : mk_upper(nextRnd(), int'(r[11:8]) % 12));
          wr_word(s[0], e, 1, nextRnd());
        end
      for (int q = 0; q < 24; q++) begin
        logic [31:0] r = nextRnd();
        logic [31:0] a = nextRnd();
        logic sd = r[0];
        logic [31:0] u = shUp[sd][r[2:1]];
        logic [31:0] m = (u & 32'h0000_1FFC) << 15;
        if (r[4:3] != 0) a = (u & 32'hFFFE_0000) | (a & m) | (a & 32'h0001_FFFF);
        codeXlateEn = (r[9:6] != 0); dataXlateEn = (r[13:10] != 0);
        case (q % 6)
          0: look(a, ~sd, r[5], r[14], "R2");
          1: look(a, ~sd, r[5], r[14], "R3");
          2: look(a, ~sd, r[5], r[14], "R4");
          3: look(a, ~sd, r[5], r[14], "R5");
          4: look(a, ~sd, r[5], r[14], "R7");
          default: look(a, ~sd, r[5], r[14], "R13");
        endcase
      end
      codeXlateEn = 1; dataXlateEn = 1;
    end
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #3000000;
    testsRun++; testsFailed++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule